// File: doc/BRIEF.md
# Ordered Frame Spreading Input Scheduler

This block sits on the ingress side of a two-stage load-balanced switch with `N_PORTS` ports. Each arriving cell names its destination output. The block stores the cell in a FIFO that belongs to that output flow. On every slot strobe it sends at most one cell toward one of the first-stage middle ports. Each cell leaves tagged with the middle port, its flow and a per-flow sequence number, so that the output side can put the flow back in order.

Scheduling works one frame at a time. A frame is `N_PORTS` consecutive strobes, and a new flow is chosen only at a frame boundary. A flow that holds at least a full frame of cells wins over flows that hold less. The full flows take turns under their own rotating pointer. When no flow is full, the non-empty flows are served round-robin under a second pointer, and the slots that the chosen flow cannot fill stay idle. Each flow has its own middle-port pointer, which steps by one for every cell sent, so consecutive cells of a flow never share a middle port.

Top module: `ofs_spread_sched`

## Requirements
- R1: After reset `dep_valid` is 0 and every `q_full` bit is 0. The first cell any flow sends goes to middle port 0 with sequence number 0.
- R2: A cell with `arr_valid`=1 and `arr_dest`=d is stored in flow d's FIFO. Each flow's cells depart carrying their payloads in arrival order.
- R3: A flow's middle port starts at 0 and steps by one, modulo `N_PORTS`, for each cell it actually sends. Two consecutive cells of a flow never use the same middle port.
- R4: Once a frame starts, it occupies exactly `N_PORTS` strobes, counting the start strobe. Only the chosen flow may send during those strobes.
- R5: At a frame boundary, if any flow holds `N_PORTS` or more cells, one such flow is chosen. It sends one cell on each of the frame's `N_PORTS` strobes.
- R6: When several flows are full, the lowest flow index at or after a rotating full-frame pointer wins. That pointer starts at 0 and moves to one past the chosen flow.
- R7: When no flow is full, the non-empty flow at or after a separate round-robin pointer (start 0, moves to one past the chosen flow) is chosen. It sends min(its count, `N_PORTS`) cells on the first strobes of the frame, and the remaining strobes of the frame give `dep_valid`=0.
- R8: `dep_seq` of a flow starts at 0 and increments by one per cell sent, wrapping modulo 2^`SEQ_W`.
- R9: `q_full[d]` is 1 exactly while flow d holds `DEPTH` cells. An arrival to a full flow is dropped and never departs.
- R10: A strobe at a frame boundary with all flows empty starts no frame and gives `dep_valid`=0. The next strobe is again a boundary.
- R11: The departure outputs are registered. `dep_valid` is 1 only in the cycle right after a strobe cycle that sent a cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arr_valid | input | 1 | Arriving cell present this cycle |
| arr_dest | input | $clog2(N_PORTS) | Destination output (flow) of the arriving cell |
| arr_data | input | DATA_W | Payload of the arriving cell |
| slot | input | 1 | Time-slot strobe, one cycle per slot |
| q_full | output | N_PORTS | Per-flow queue-full flags |
| dep_valid | output | 1 | Departing cell valid |
| dep_port | output | $clog2(N_PORTS) | Middle port the cell is spread to |
| dep_flow | output | $clog2(N_PORTS) | Flow (destination output) of the departing cell |
| dep_seq | output | SEQ_W | Per-flow sequence number |
| dep_data | output | DATA_W | Payload of the departing cell |

## Verification
A corrupted middle-port pointer shows up at the next cell that flow sends, as a wrong or repeated `dep_port`. A wrong frame counter or budget lets a second flow send inside a frame, or leaves a strobe idle when it should carry a cell, within one frame of `N_PORTS` strobes. A fault in a selection pointer is seen at the next frame boundary as a wrong `dep_flow`. Queue faults appear as wrong payloads or a wrong `q_full` bit on the very next departure or arrival of that flow.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  // Increment an index and wrap it at n (n need not be a power of two).
  function automatic int wrap_inc(input int v, input int n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/ofs_flow_fifo.sv
module ofs_flow_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          push,
  input  logic [DATA_W-1:0]             din,
  input  logic                          pop,
  output logic [DATA_W-1:0]             head,
  output logic [$clog2(DEPTH+1)-1:0]    count,
  output logic                          full,
  output logic                          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr;
  logic [AW-1:0]     rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  assign head  = mem[rd_ptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= AW'(ofs_pkg::wrap_inc(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= AW'(ofs_pkg::wrap_inc(int'(rd_ptr), DEPTH));
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R9: storage never exceeds its depth, never read when empty, never written when full
  a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
    int'(count) <= DEPTH);
  a_r9_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  a_r9_no_write_full: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);

endmodule

// File: rtl/ofs_rot_pick.sv
module ofs_rot_pick #(
  parameter int N = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N-1:0]          req,
  input  logic [$clog2(N)-1:0]  base,
  output logic                  found,
  output logic [$clog2(N)-1:0]  pick
);
  localparam int IW = $clog2(N);

  always_comb begin
    int c;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < N; i++) begin
      c = int'(base) + i;
      if (c >= N) c = c - N;
      if (!found && req[c]) begin
        found = 1'b1;
        pick  = IW'(c);
      end
    end
  end

  // R6/R7: the chosen index is a requester; no requester means nothing found
  a_r6_pick_requests: assert property (@(posedge clk) disable iff (rst)
    found |-> req[pick]);
  a_r7_none_when_idle: assert property (@(posedge clk) disable iff (rst)
    !found |-> (req == '0));
  a_r6_base_range: assert property (@(posedge clk) disable iff (rst)
    int'(base) < N);

endmodule

// File: rtl/ofs_spread_sched.sv
module ofs_spread_sched #(
  parameter int N_PORTS = 4,
  parameter int DEPTH   = 8,
  parameter int DATA_W  = 16,
  parameter int SEQ_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        arr_valid,
  input  logic [$clog2(N_PORTS)-1:0]  arr_dest,
  input  logic [DATA_W-1:0]           arr_data,
  input  logic                        slot,
  output logic [N_PORTS-1:0]          q_full,
  output logic                        dep_valid,
  output logic [$clog2(N_PORTS)-1:0]  dep_port,
  output logic [$clog2(N_PORTS)-1:0]  dep_flow,
  output logic [SEQ_W-1:0]            dep_seq,
  output logic [DATA_W-1:0]           dep_data
);
  localparam int IDX_W = $clog2(N_PORTS);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int BUD_W = $clog2(N_PORTS + 1);
  localparam logic [CNT_W-1:0] FRAME_CELLS = CNT_W'(N_PORTS);
  localparam logic [IDX_W-1:0] LAST_SLOT   = IDX_W'(N_PORTS - 1);

  // Per-flow storage
  logic [N_PORTS-1:0] push_v, pop_v, full_v, empty_v;
  logic [N_PORTS-1:0] full_req, ne_req;
  logic [DATA_W-1:0]  head_v [N_PORTS];
  logic [CNT_W-1:0]   cnt_v  [N_PORTS];

  // Frame state
  logic               active;
  logic [IDX_W-1:0]   frame_cnt;
  logic [IDX_W-1:0]   cur_flow;
  logic [BUD_W-1:0]   budget;
  logic [IDX_W-1:0]   full_ptr, rr_ptr;
  logic [IDX_W-1:0]   port_ptr [N_PORTS];
  logic [SEQ_W-1:0]   seq_r    [N_PORTS];

  // Selection
  logic               full_found, part_found;
  logic [IDX_W-1:0]   full_pick, part_pick;
  logic [IDX_W-1:0]   sel_now;
  logic [BUD_W-1:0]   start_budget;
  logic               start, send_now;

  genvar g;
  generate
    for (g = 0; g < N_PORTS; g++) begin : g_flow
      assign push_v[g]   = arr_valid && (arr_dest == IDX_W'(g)) && !full_v[g];
      assign pop_v[g]    = send_now && (sel_now == IDX_W'(g));
      assign full_req[g] = (cnt_v[g] >= FRAME_CELLS);
      assign ne_req[g]   = !empty_v[g];

      ofs_flow_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push_v[g]),
        .din   (arr_data),
        .pop   (pop_v[g]),
        .head  (head_v[g]),
        .count (cnt_v[g]),
        .full  (full_v[g]),
        .empty (empty_v[g])
      );
    end
  endgenerate

  assign q_full = full_v;

  ofs_rot_pick #(.N(N_PORTS)) u_full_pick (
    .clk   (clk),
    .rst   (rst),
    .req   (full_req),
    .base  (full_ptr),
    .found (full_found),
    .pick  (full_pick)
  );

  ofs_rot_pick #(.N(N_PORTS)) u_part_pick (
    .clk   (clk),
    .rst   (rst),
    .req   (ne_req),
    .base  (rr_ptr),
    .found (part_found),
    .pick  (part_pick)
  );

  always_comb begin
    if (active)          sel_now = cur_flow;
    else if (full_found) sel_now = full_pick;
    else                 sel_now = part_pick;

    if (cnt_v[sel_now] >= FRAME_CELLS) start_budget = BUD_W'(N_PORTS);
    else                               start_budget = BUD_W'(cnt_v[sel_now]);

    start    = slot && !active && (full_found || part_found);
    send_now = active ? (slot && (budget != '0)) : start;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      frame_cnt <= '0;
      cur_flow  <= '0;
      budget    <= '0;
      full_ptr  <= '0;
      rr_ptr    <= '0;
      dep_valid <= 1'b0;
      dep_port  <= '0;
      dep_flow  <= '0;
      dep_seq   <= '0;
      dep_data  <= '0;
      for (int i = 0; i < N_PORTS; i++) begin
        port_ptr[i] <= '0;
        seq_r[i]    <= '0;
      end
    end else begin
      dep_valid <= send_now;
      if (send_now) begin
        dep_port          <= port_ptr[sel_now];
        dep_flow          <= sel_now;
        dep_seq           <= seq_r[sel_now];
        dep_data          <= head_v[sel_now];
        port_ptr[sel_now] <= IDX_W'(ofs_pkg::wrap_inc(int'(port_ptr[sel_now]), N_PORTS));
        seq_r[sel_now]    <= seq_r[sel_now] + 1'b1;
      end
      if (slot) begin
        if (!active) begin
          if (start) begin
            cur_flow  <= sel_now;
            budget    <= start_budget - 1'b1;
            frame_cnt <= IDX_W'(1);
            active    <= 1'b1;
            if (full_found)
              full_ptr <= IDX_W'(ofs_pkg::wrap_inc(int'(full_pick), N_PORTS));
            else
              rr_ptr   <= IDX_W'(ofs_pkg::wrap_inc(int'(part_pick), N_PORTS));
          end
        end else begin
          if (budget != '0) budget <= budget - 1'b1;
          if (frame_cnt == LAST_SLOT) begin
            active    <= 1'b0;
            frame_cnt <= '0;
          end else begin
            frame_cnt <= frame_cnt + 1'b1;
          end
        end
      end
    end
  end

  // R11: a departure only follows a strobe
  a_r11_valid_after_slot: assert property (@(posedge clk) disable iff (rst)
    dep_valid |-> $past(slot));
  // R4: frame position and activity agree
  a_r4_frame_pos_active: assert property (@(posedge clk) disable iff (rst)
    active |-> (frame_cnt != '0));
  a_r4_frame_pos_idle: assert property (@(posedge clk) disable iff (rst)
    !active |-> (frame_cnt == '0));
  // R7: remaining budget fits in the rest of the frame
  a_r7_budget_bound: assert property (@(posedge clk) disable iff (rst)
    int'(budget) < N_PORTS);
  // R5: a full flow wins the boundary when one exists
  a_r5_full_wins: assert property (@(posedge clk) disable iff (rst)
    (slot && !active && (|full_req)) |-> (cnt_v[sel_now] >= FRAME_CELLS));
  // R10: empty boundary gives no departure
  a_r10_empty_boundary: assert property (@(posedge clk) disable iff (rst)
    (slot && !active && !(|ne_req)) |=> !dep_valid);

endmodule

// File: tb/sim_ofs_spread_sched.sv
`timescale 1ns/1ps
module sim_ofs_spread_sched;
  localparam int N  = 4;
  localparam int D  = 8;
  localparam int DW = 16;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          arr_valid = 1'b0;
  logic [1:0]    arr_dest = '0;
  logic [DW-1:0] arr_data = '0;
  logic          slot = 1'b0;
  logic [N-1:0]  q_full;
  logic          dep_valid;
  logic [1:0]    dep_port, dep_flow;
  logic [SW-1:0] dep_seq;
  logic [DW-1:0] dep_data;

  always #2 clk = ~clk;

  ofs_spread_sched #(.N_PORTS(N), .DEPTH(D), .DATA_W(DW), .SEQ_W(SW)) u0 (
    .clk(clk), .rst(rst), .arr_valid(arr_valid), .arr_dest(arr_dest),
    .arr_data(arr_data), .slot(slot), .q_full(q_full), .dep_valid(dep_valid),
    .dep_port(dep_port), .dep_flow(dep_flow), .dep_seq(dep_seq), .dep_data(dep_data)
  );

  int total = 0;
  int bad   = 0;

  // Reference model state, from the requirements
  int mq [N][D];
  int mcnt [N];
  int mport [N];
  int mseq [N];
  int lastp [N];
  int mfp = 0, mrp = 0;
  bit mact = 0;
  int mcur = 0, mbud = 0, mleft = 0;
  int dcount = 1;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic do_push(input int d, input int val);
    @(negedge clk);
    arr_valid = 1'b1;
    arr_dest  = 2'(d);
    arr_data  = DW'(val);
    if (mcnt[d] < D) begin
      mq[d][mcnt[d]] = val;
      mcnt[d]++;
    end
    @(negedge clk);
    arr_valid = 1'b0;
    for (int f = 0; f < N; f++)
      chk("R9", "q_full", int'(q_full[f]), (mcnt[f] == D) ? 1 : 0);
  endtask

  task automatic do_slot();
    bit    ev;
    int    ef, ep, es, ed;
    string ftag;
    ev = 0; ef = 0; ep = 0; es = 0; ed = 0;
    ftag = "R10";
    @(negedge clk);
    slot = 1'b1;
    if (!mact) begin
      bit got;
      got = 0;
      for (int i = 0; i < N; i++) begin
        int c;
        c = (mfp + i) % N;
        if (!got && mcnt[c] >= N) begin got = 1; mcur = c; ftag = "R6"; end
      end
      if (got) mfp = (mcur + 1) % N;
      else begin
        for (int i = 0; i < N; i++) begin
          int c;
          c = (mrp + i) % N;
          if (!got && mcnt[c] > 0) begin got = 1; mcur = c; ftag = "R7"; end
        end
        if (got) mrp = (mcur + 1) % N;
      end
      if (got) begin
        mact  = 1;
        mbud  = (mcnt[mcur] >= N) ? N : mcnt[mcur];
        mleft = N;
      end
    end else begin
      ftag = (mbud > 0) ? "R4" : "R7";
    end
    if (mact) begin
      if (mbud > 0) begin
        ev = 1; ef = mcur; ep = mport[mcur]; es = mseq[mcur]; ed = mq[mcur][0];
        for (int k = 0; k < D - 1; k++) mq[mcur][k] = mq[mcur][k+1];
        mcnt[mcur]--;
        mport[mcur] = (mport[mcur] + 1) % N;
        mseq[mcur]  = (mseq[mcur] + 1) % (1 << SW);
        mbud--;
      end
      mleft--;
      if (mleft == 0) mact = 0;
    end
    @(negedge clk);
    slot = 1'b0;
    chk(ftag, "dep_valid", int'(dep_valid), int'(ev));
    if (ev && dep_valid) begin
      chk(ftag, "dep_flow", int'(dep_flow), ef);
      chk((es == 0 && ep == 0) ? "R1" : "R3", "dep_port", int'(dep_port), ep);
      chk("R8", "dep_seq", int'(dep_seq), es);
      chk("R2", "dep_data", int'(dep_data), ed);
      total++;
      if (lastp[dep_flow] == int'(dep_port)) begin
        bad++;
        $display("FAIL R3 repeated port actual=%0d expected=%0d", dep_port, (lastp[dep_flow] + 1) % N);
      end
      lastp[dep_flow] = int'(dep_port);
    end
  endtask

  task automatic quiet_check();
    @(negedge clk);
    chk("R11", "dep_valid after gap", int'(dep_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    for (int f = 0; f < N; f++) begin
      mcnt[f] = 0; mport[f] = 0; mseq[f] = 0; lastp[f] = -1;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "dep_valid at reset", int'(dep_valid), 0);
    chk("R1", "q_full at reset", int'(q_full), 0);

    // R10: strobes with nothing queued
    do_slot();
    do_slot();

    // R7: a single cell, then three idle strobes of its frame
    do_push(2, dcount++);
    for (int s = 0; s < N; s++) do_slot();
    quiet_check();

    // R5/R6: two full flows and one partial flow
    for (int k = 0; k < N; k++) do_push(1, dcount++);
    for (int k = 0; k < N; k++) do_push(3, dcount++);
    do_push(0, dcount++);
    do_push(0, dcount++);
    for (int s = 0; s < 3 * N; s++) do_slot();

    // R9: overfill flow 0, drops must never depart
    for (int k = 0; k < D + 3; k++) do_push(0, dcount++);
    for (int s = 0; s < 4 * N; s++) do_slot();
    quiet_check();

    // R8: push enough through flow 2 to wrap its sequence number
    for (int r = 0; r < 70; r++) begin
      for (int k = 0; k < N; k++) do_push(2, dcount++);
      for (int s = 0; s < N; s++) do_slot();
    end

    // Mixed sweep of arrivals and strobes
    for (int it = 0; it < 400; it++) begin
      int np, ns;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      np = int'(lfsr[1:0]);
      for (int k = 0; k < np; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        do_push(int'(lfsr[3:2]), dcount++);
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ns = 1 + int'(lfsr[0]);
      for (int s = 0; s < ns; s++) do_slot();
    end

    // Drain everything
    for (int s = 0; s < 12 * N * D; s++) do_slot();
    for (int f = 0; f < N; f++) chk("R2", "model drained", mcnt[f], 0);
    quiet_check();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule